// File: doc/BRIEF.md
# I2C Slave Own-Address Recognizer

This block decides whether an I2C transfer is addressed to this device. A byte-level shift engine, kept outside the block, hands it each received byte along with a flag that marks the first byte after a START or repeated START. The block compares address bytes against two CPU-programmable own-address registers. It returns an acknowledge decision for every address byte. When addressing completes it raises a one-cycle interrupt request and drives a selected flag together with the transfer direction.

The block supports three ways of being addressed. The first is an ordinary 7-bit address. The second is the general-call address, which is enabled by a bit in the primary register. The third is a 10-bit address, which is used when the primary register holds the 11110 prefix. In 10-bit mode the header byte is acknowledged quietly, with no interrupt. The interrupt comes only after the second byte matches. A later repeated START with a read header is accepted directly.

Received bytes arrive on a valid/ready stream. A byte transfers on a cycle where `rx_valid` and `rx_ready` are both high. The block lowers `rx_ready` for exactly the one cycle in which it presents its acknowledge decision. The engine must hold a byte and its first-byte flag stable until the byte is accepted.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset both address registers read 00h, and `selected`, `dir_read`, `ack_valid` and `irq` are 0.
- R2: A CPU write to offset C8h sets the primary register and a write to offset C9h sets the extended register. `cpu_rdata` returns the register at `cpu_addr`, and returns 00h for any other offset.
- R3: When primary bits [7:3] are not 11110, a first byte whose bits [7:1] equal primary bits [7:1] (and are not all zero) is acknowledged. This is `ack_valid`=1 and `ack`=1 in the cycle after acceptance, with `irq`=1 in that same cycle. `selected` becomes 1, and `dir_read` takes the byte's bit 0 (1 = read).
- R4: A first byte that matches nothing gets `ack_valid`=1 and `ack`=0, with no `irq`. It also clears `selected` and `dir_read`. `dir_read` is 0 whenever `selected` is 0.
- R5: The first byte 00h is acknowledged with `irq` and selection as a write only when primary bit 0 is 1. When that bit is 0, the byte is refused.
- R6: In 10-bit mode (primary bits [7:3] = 11110), the first byte {11110, primary[2:1], 0} is acknowledged without `irq` and without selecting.
- R7: The next non-first byte after an accepted 10-bit header is acknowledged with `irq`, and selects as a write, if it equals the extended register. Otherwise it is refused and the block returns to idle.
- R8: After a completed 10-bit selection, a first byte {11110, primary[2:1], 1} is acknowledged with `irq` and selects as a read. Without a prior 10-bit selection, the same byte is refused.
- R9: A `stop_seen` pulse clears `selected`, any pending 10-bit header and the 10-bit selection memory. A non-first byte arriving in idle or selected state is accepted and given no response (`ack_valid` stays 0).
- R10: Address comparisons use copies of the registers taken only while idle. A CPU write made during an address phase does not affect that phase.
- R11: `rx_ready` is 0 in the cycle where `ack_valid` is 1, and is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received byte available |
| rx_ready | output | 1 | Block can accept a byte this cycle |
| rx_data | input | 8 | Received byte |
| rx_first | input | 1 | Byte is the first after START or repeated START |
| stop_seen | input | 1 | One-cycle pulse on a STOP condition |
| ack_valid | output | 1 | Acknowledge decision present (one cycle) |
| ack | output | 1 | 1 = acknowledge, 0 = refuse |
| irq | output | 1 | One-cycle interrupt request on completed addressing |
| selected | output | 1 | Device is the addressed slave |
| dir_read | output | 1 | Direction of the selected transfer, 1 = read |
| cpu_sel | input | 1 | CPU access strobe |
| cpu_wr | input | 1 | CPU access is a write |
| cpu_addr | input | 8 | CPU register offset |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data |

## Verification
The hardest case to reach is a CPU write that lands in the middle of a 10-bit address phase. To reach it, the bench sends a matching header and then, before the second byte, rewrites the extended register. It then checks that the old value is still the one honoured. After a STOP it repeats the two-byte sequence and checks that the new value now applies. The repeated-START read path needs the 10-bit selection memory set beforehand. The bench therefore checks it once after a completed write selection and once after a STOP, where it must be refused.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int BYTE_W = 8;
  localparam logic [4:0] TEN_PREFIX = 5'b11110;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HI_OK = 2'd1,
    ST_SEL   = 2'd2
  } am_state_t;
endpackage

// File: rtl/i2c_am_regs.sv
module i2c_am_regs #(
  parameter int AW = 8,
  parameter logic [AW-1:0] BASE = 8'hC8,
  parameter int NREG = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cpu_sel,
  input  logic                          cpu_wr,
  input  logic [AW-1:0]                 cpu_addr,
  input  logic [i2c_am_pkg::BYTE_W-1:0] cpu_wdata,
  output logic [i2c_am_pkg::BYTE_W-1:0] cpu_rdata,
  output logic [NREG*i2c_am_pkg::BYTE_W-1:0] regs_flat
);
  localparam int BW = i2c_am_pkg::BYTE_W;

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam logic [AW-1:0] SLOT = BASE + AW'(g);
    logic [BW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (cpu_sel && cpu_wr && cpu_addr == SLOT)
        q <= cpu_wdata;
    end
    assign regs_flat[g*BW +: BW] = q;
  end

  always_comb begin
    cpu_rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (cpu_addr == BASE + AW'(i))
        cpu_rdata = regs_flat[i*BW +: BW];
  end
endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp (
  input  logic [7:0] byte_in,
  input  logic [7:0] pri,
  input  logic [7:0] ext,
  output logic       ten_mode,
  output logic       gc_hit,
  output logic       hit7,
  output logic       hdr_hit,
  output logic       lo_hit
);
  import i2c_am_pkg::*;

  always_comb begin
    ten_mode = (pri[7:3] == TEN_PREFIX);
    gc_hit   = pri[0] && (byte_in == 8'h00);
    hit7     = !ten_mode && (byte_in[7:1] == pri[7:1]) && (byte_in[7:1] != 7'd0);
    hdr_hit  = ten_mode && (byte_in[7:3] == TEN_PREFIX) && (byte_in[2:1] == pri[2:1]);
    lo_hit   = (byte_in == ext);
  end
endmodule

// File: rtl/i2c_am_ctl.sv
module i2c_am_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic       rx_first,
  input  logic       rx_lsb,
  input  logic       stop_seen,
  input  logic [7:0] live_pri,
  input  logic [7:0] live_ext,
  input  logic       ten_mode,
  input  logic       gc_hit,
  input  logic       hit7,
  input  logic       hdr_hit,
  input  logic       lo_hit,
  output logic [7:0] sh_pri,
  output logic [7:0] sh_ext,
  output logic       rx_ready,
  output logic       ack_valid,
  output logic       ack,
  output logic       irq,
  output logic       selected,
  output logic       dir_read
);
  import i2c_am_pkg::*;

  am_state_t st;
  logic      ten_done;
  logic      acc;

  assign rx_ready = !ack_valid;
  assign acc      = rx_valid && rx_ready;

  // Register copies follow the CPU registers only while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_pri <= '0;
      sh_ext <= '0;
    end else if (st == ST_IDLE) begin
      sh_pri <= live_pri;
      sh_ext <= live_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ten_done  <= 1'b0;
      ack_valid <= 1'b0;
      ack       <= 1'b0;
      irq       <= 1'b0;
      selected  <= 1'b0;
      dir_read  <= 1'b0;
    end else begin
      ack_valid <= 1'b0;
      ack       <= 1'b0;
      irq       <= 1'b0;
      if (stop_seen) begin
        st       <= ST_IDLE;
        ten_done <= 1'b0;
        selected <= 1'b0;
        dir_read <= 1'b0;
      end else if (acc && rx_first) begin
        ack_valid <= 1'b1;
        if (gc_hit) begin
          ack <= 1'b1; irq <= 1'b1; selected <= 1'b1; dir_read <= 1'b0;
          st <= ST_SEL; ten_done <= 1'b0;
        end else if (hit7) begin
          ack <= 1'b1; irq <= 1'b1; selected <= 1'b1; dir_read <= rx_lsb;
          st <= ST_SEL; ten_done <= 1'b0;
        end else if (hdr_hit && !rx_lsb) begin
          ack <= 1'b1; selected <= 1'b0; dir_read <= 1'b0;
          st <= ST_HI_OK; ten_done <= 1'b0;
        end else if (hdr_hit && rx_lsb && ten_done) begin
          ack <= 1'b1; irq <= 1'b1; selected <= 1'b1; dir_read <= 1'b1;
          st <= ST_SEL;
        end else begin
          selected <= 1'b0; dir_read <= 1'b0;
          st <= ST_IDLE; ten_done <= 1'b0;
        end
      end else if (acc && st == ST_HI_OK) begin
        ack_valid <= 1'b1;
        if (ten_mode && lo_hit) begin
          ack <= 1'b1; irq <= 1'b1; selected <= 1'b1; dir_read <= 1'b0;
          st <= ST_SEL; ten_done <= 1'b1;
        end else begin
          st <= ST_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int CPU_AW = 8,
  parameter logic [CPU_AW-1:0] REG_BASE = 8'hC8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_first,
  input  logic              stop_seen,
  output logic              ack_valid,
  output logic              ack,
  output logic              irq,
  output logic              selected,
  output logic              dir_read,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata
);
  localparam int NREG = 2;

  logic [NREG*8-1:0] regs_flat;
  logic [7:0] sh_pri, sh_ext;
  logic ten_mode, gc_hit, hit7, hdr_hit, lo_hit;

  i2c_am_regs #(.AW(CPU_AW), .BASE(REG_BASE), .NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .regs_flat(regs_flat)
  );

  i2c_am_cmp u_cmp (
    .byte_in(rx_data), .pri(sh_pri), .ext(sh_ext),
    .ten_mode(ten_mode), .gc_hit(gc_hit), .hit7(hit7),
    .hdr_hit(hdr_hit), .lo_hit(lo_hit)
  );

  i2c_am_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_first(rx_first),
    .rx_lsb(rx_data[0]), .stop_seen(stop_seen),
    .live_pri(regs_flat[7:0]), .live_ext(regs_flat[15:8]),
    .ten_mode(ten_mode), .gc_hit(gc_hit), .hit7(hit7),
    .hdr_hit(hdr_hit), .lo_hit(lo_hit),
    .sh_pri(sh_pri), .sh_ext(sh_ext), .rx_ready(rx_ready),
    .ack_valid(ack_valid), .ack(ack), .irq(irq),
    .selected(selected), .dir_read(dir_read)
  );
endmodule

// File: rtl/i2c_am_chk.sv
module i2c_am_chk (
  input logic clk,
  input logic rst_n,
  input logic stop_seen,
  input logic ack_valid,
  input logic ack,
  input logic irq,
  input logic selected,
  input logic dir_read
);
  // R3
  irq_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ack_valid && ack && selected));

  // R4
  nack_deselects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack) |-> !selected);

  // R4
  dir_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !selected |-> !dir_read);

  // R9
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !selected);

  // R11
  single_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> !ack_valid);

  // R3
  select_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selected) |-> irq);
endmodule

bind i2c_addr_match i2c_am_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stop_seen(stop_seen), .ack_valid(ack_valid),
  .ack(ack), .irq(irq), .selected(selected), .dir_read(dir_read)
);

// File: tb/sim_i2c_addr_match.sv
`timescale 1ns/1ps
module sim_i2c_addr_match;
  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_first = 0, stop_seen = 0;
  logic [7:0] rx_data = 0;
  logic rx_ready, ack_valid, ack, irq, selected, dir_read;
  logic cpu_sel = 0, cpu_wr = 0;
  logic [7:0] cpu_addr = 0, cpu_wdata = 0, cpu_rdata;
  int errs = 0, checks = 0;
  bit done = 0;
  logic [4:0] got;
  logic ready_after;

  always #2.5 clk = ~clk;

  i2c_addr_match u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic first);
    @(negedge clk);
    rx_valid = 1; rx_data = b; rx_first = first;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 0; rx_first = 0;
    got = {ack_valid, ack, irq, selected, dir_read};
    ready_after = rx_ready;
  endtask

  // expected vector {ack_valid, ack, irq, selected, dir_read}
  task automatic expect_resp(input logic [4:0] e, input string tag);
    chk(got == e, tag, 16'(got), 16'(e));
  endtask

  task automatic cpu_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_sel = 1; cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 0; cpu_wr = 0;
  endtask

  task automatic stop_pulse();
    @(negedge clk); stop_seen = 1;
    @(negedge clk); stop_seen = 0;
    chk(selected == 0, "R9 stop deselects", 16'(selected), 16'd0);
  endtask

  task automatic t_reset();
    chk({ack_valid, irq, selected, dir_read} == 4'b0, "R1 outputs", 16'({ack_valid, irq, selected, dir_read}), 16'd0);
    cpu_addr = 8'hC8; #1;
    chk(cpu_rdata == 8'h00, "R1 primary", 16'(cpu_rdata), 16'h00);
    cpu_addr = 8'hC9; #1;
    chk(cpu_rdata == 8'h00, "R1 extended", 16'(cpu_rdata), 16'h00);
  endtask

  task automatic t_regs();
    cpu_write(8'hC8, 8'h5C);
    cpu_write(8'hC9, 8'hE1);
    cpu_write(8'hCA, 8'h77);
    cpu_addr = 8'hC8; #1;
    chk(cpu_rdata == 8'h5C, "R2 primary readback", 16'(cpu_rdata), 16'h5C);
    cpu_addr = 8'hC9; #1;
    chk(cpu_rdata == 8'hE1, "R2 extended readback", 16'(cpu_rdata), 16'hE1);
    cpu_addr = 8'hCA; #1;
    chk(cpu_rdata == 8'h00, "R2 unmapped offset", 16'(cpu_rdata), 16'h00);
  endtask

  task automatic t_seven();
    cpu_write(8'hC8, 8'hA4);
    send(8'hA5, 1); expect_resp(5'b11111, "R3 7-bit read match");
    chk(ready_after == 0, "R11 ready low during response", 16'(ready_after), 16'd0);
    @(negedge clk);
    chk(rx_ready == 1, "R11 ready back high", 16'(rx_ready), 16'd1);
    send(8'h33, 0); expect_resp(5'b00011, "R9 data byte gets no response");
    send(8'hA4, 1); expect_resp(5'b11110, "R3 repeated start write match");
    stop_pulse();
    send(8'hA6, 1); expect_resp(5'b10000, "R4 7-bit mismatch");
    send(8'h00, 1); expect_resp(5'b10000, "R5 general call disabled");
    cpu_write(8'hC8, 8'hA5);
    send(8'h00, 1); expect_resp(5'b11110, "R5 general call enabled");
    stop_pulse();
  endtask

  task automatic t_ten();
    cpu_write(8'hC8, 8'hF2);
    cpu_write(8'hC9, 8'h5A);
    send(8'hA4, 1); expect_resp(5'b10000, "R4 7-bit byte in 10-bit mode");
    send(8'hF3, 1); expect_resp(5'b10000, "R8 read header without selection");
    send(8'hF2, 1); expect_resp(5'b11000, "R6 header acked no irq");
    send(8'h5A, 0); expect_resp(5'b11110, "R7 low byte match");
    send(8'hF3, 1); expect_resp(5'b11111, "R8 repeated start read");
    stop_pulse();
    send(8'hF3, 1); expect_resp(5'b10000, "R9 read header after stop");
    send(8'hF4, 1); expect_resp(5'b10000, "R6 header upper bits mismatch");
    send(8'hF2, 1); expect_resp(5'b11000, "R6 header again");
    send(8'h5B, 0); expect_resp(5'b10000, "R7 low byte mismatch");
    send(8'h5A, 0); expect_resp(5'b00000, "R7 idle after mismatch");
    send(8'hF2, 1); expect_resp(5'b11000, "R6 header before stop");
    stop_pulse();
    send(8'h5A, 0); expect_resp(5'b00000, "R9 stop drops pending header");
  endtask

  task automatic t_shadow();
    send(8'hF2, 1); expect_resp(5'b11000, "R10 header");
    cpu_write(8'hC9, 8'h33);
    send(8'h5A, 0); expect_resp(5'b11110, "R10 old extended value used");
    stop_pulse();
    send(8'hF2, 1); expect_resp(5'b11000, "R10 header after stop");
    send(8'h33, 0); expect_resp(5'b11110, "R10 new value after idle");
    stop_pulse();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_seven();
    t_ten();
    t_shadow();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule